// File: doc/BRIEF.md
# Row-Buffered Memory Bank Command Engine

This block models one memory bank sitting on a shared section bus that is one word wide. The bank keeps a small storage array and a few static row buffers. Each buffer holds one whole open row, so the buffers act as an explicitly addressed cache of rows. Whole rows move between the array and a buffer. Single words move between a buffer and the bus. The bank has no column decoder.

A controller sends commands together with a bank number. A bank acts only on commands that carry its own number. Array commands (row fetch, row write-back and per-row refresh) run for three stages and hold `ready` low while they run. Word commands go through a two-stage pipeline.

A row fetch may be told not to restore the array. In that case the array row is lost (it reads back as zero) until a write-back stores a buffer into it again. This lets many word updates build up in a buffer and then go back to the array in a single write.

Top module: `rbank_engine`

## Requirements
- R1: A command counts only when `cmd_valid` is 1 and `cmd_bank` equals the `BANK_ID` parameter. Any other command changes no array, buffer or output state and raises no error. Opcodes on `cmd_op`:
  - 0 idle
  - 1 precharge
  - 2 row fetch into buffer
  - 3 buffer write-back to row
  - 4 word read to bus
  - 5 word write from bus
  - 6 refresh row
  - 7 invalid, rejected
- R2: After reset `precharged` is 1. An accepted precharge sets it to 1. Opcodes 2, 3 and 6 are accepted only while `precharged` is 1 and `ready` is 1, and they clear `precharged`. An array command that arrives while the bank is not precharged is dropped.
- R3: A row fetch (2) copies array row `cmd_row` into buffer `cmd_buf`. The new contents can be read by a word read issued three or more cycles after the fetch command.
- R4: A row fetch with `cmd_restore`=1 leaves the array row intact. With `cmd_restore`=0 the array row becomes all zeros.
- R5: A write-back (3) takes a copy of buffer `cmd_buf` in the cycle of the command and stores it into array row `cmd_row`.
- R6: A refresh (6) keeps `ready` low for two cycles and changes no buffer and no array row.
- R7: A word read (4) of word `cmd_word` of buffer `cmd_buf` raises `rvalid` for exactly one cycle, two cycles after the command, with that word on `rdata`.
- R8: `rdata` is all zeros in every cycle where `rvalid` is 0.
- R9: A word write (5) stores `wdata` into word `cmd_word` of buffer `cmd_buf`. Word w occupies row bits [w*WIDTH +: WIDTH]. The other words are unchanged. A read issued two or more cycles after the write sees the new value.
- R10: For the two cycles after an accepted array command, `ready` is 0. During that window:
  - array commands and precharge are rejected;
  - word commands to the buffer the running command uses are rejected;
  - word commands to any other buffer, or any word command during a refresh, are accepted.
- R11: `err` is 1 for exactly the one cycle after a rejected command, and is 0 otherwise.
- R12: Different buffers hold different rows at the same time, and each keeps its contents independently.
- R13: After reset every array row and every buffer is zero, `ready` is 1, and `rvalid` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_bank | input | BANK_W | Target bank number |
| cmd_row | input | ROW_W | Array row for fetch, write-back and refresh |
| cmd_buf | input | BUF_W | Row buffer index |
| cmd_word | input | WORD_W | Word index inside a buffer |
| cmd_restore | input | 1 | Restore the array row on a fetch |
| wdata | input | WIDTH | Word for a word write |
| rdata | output | WIDTH | Read word, zero when not valid |
| rvalid | output | 1 | Read data valid strobe |
| ready | output | 1 | No array command in progress |
| precharged | output | 1 | Bit-lines precharged; array access allowed |
| err | output | 1 | Previous command was rejected |

## Verification
The bound checker watches the command-level timing on every clock. It covers these rules:
- the idle bus stays zero;
- refused array commands raise the error strobe;
- the busy window lasts exactly two cycles;
- a read returns two cycles after it is issued;
- the precharge state changes only when expected;
- commands for a foreign bank are ignored.

Only the bench scenarios can show that data is correct, because that depends on what was written earlier. Those scenarios cover:
- a row lost after a fetch without restore;
- a restored row that survives;
- a refresh that leaves the buffers untouched;
- a word write that is refused because its buffer is in use;
- two buffers holding separate rows.

// File: rtl/rbank_pkg.sv
// Shared opcode encoding and stage count for the row-buffered bank engine.
// Assumes a 3-bit opcode field on the command bus.
package rbank_pkg;
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PRE  = 3'd1,
        OP_RD2B = 3'd2,
        OP_WR2B = 3'd3,
        OP_RD2S = 3'd4,
        OP_WR2S = 3'd5,
        OP_REF  = 3'd6,
        OP_BAD  = 3'd7
    } rbank_op_e;

    // Number of pipeline stages in an array command (decode, access, latch).
    localparam int ARRAY_STAGES = 3;

    // True for commands that touch the storage array.
    function automatic logic is_array_op(input logic [2:0] op);
        return (op == OP_RD2B) || (op == OP_WR2B) || (op == OP_REF);
    endfunction
endpackage

// File: rtl/rbank_decode.sv
// Command acceptance logic: checks bank match, precharge state, busy state
// and buffer conflicts; produces one accept strobe per command class.
// Assumes cmd_buf indexes an existing buffer.
module rbank_decode
    import rbank_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int BANK_ID = 1,
    parameter int BUF_W   = 1
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [BUF_W-1:0]  cmd_buf,
    input  logic              busy,
    input  logic              precharged,
    input  logic              busy_has_buf,
    input  logic [BUF_W-1:0]  busy_buf,
    output logic              acc_pre,
    output logic              acc_arr,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic              reject
);
    logic hit;
    logic conflict;

    // Classify the incoming command and decide whether it may proceed.
    always_comb begin
        hit      = cmd_valid && (cmd_bank == BANK_W'(BANK_ID)) && (cmd_op != OP_IDLE);
        conflict = busy && busy_has_buf && (cmd_buf == busy_buf);
        acc_pre  = hit && (cmd_op == OP_PRE) && !busy;
        acc_arr  = hit && is_array_op(cmd_op) && !busy && precharged;
        acc_rd   = hit && (cmd_op == OP_RD2S) && !conflict;
        acc_wr   = hit && (cmd_op == OP_WR2S) && !conflict;
        reject   = hit && !(acc_pre || acc_arr || acc_rd || acc_wr);
    end
endmodule

// File: rtl/rbank_array.sv
// Storage array plus the array-command sequencer. An accepted fetch,
// write-back or refresh runs for ARRAY_STAGES cycles; its effect lands on the
// last stage edge. A write-back copies its buffer in the command cycle.
// Assumes the decoder never accepts an array command while busy.
module rbank_array
    import rbank_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int ROW_W    = 3,
    parameter int BUF_W    = 1,
    parameter int ROW_BITS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_pre,
    input  logic                acc_arr,
    input  logic [2:0]          op_in,
    input  logic [ROW_W-1:0]    row_in,
    input  logic [BUF_W-1:0]    buf_in,
    input  logic                restore_in,
    input  logic [ROW_BITS-1:0] buf_row_in,
    output logic                busy,
    output logic                busy_has_buf,
    output logic [BUF_W-1:0]    busy_buf,
    output logic                precharged,
    output logic                ld_en,
    output logic [BUF_W-1:0]    ld_buf,
    output logic [ROW_BITS-1:0] ld_data
);
    localparam int          CNT_W    = $clog2(ARRAY_STAGES + 1);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(ARRAY_STAGES - 1);

    logic [ROW_BITS-1:0] mem [ROWS];
    logic [CNT_W-1:0]    cnt;
    logic [2:0]          op_q;
    logic [ROW_W-1:0]    row_q;
    logic [BUF_W-1:0]    buf_q;
    logic                restore_q;
    logic [ROW_BITS-1:0] snap;
    logic                pre_q;
    logic                last_stage;

    assign last_stage   = (cnt == CNT_W'(1));
    assign busy         = (cnt != '0);
    assign busy_has_buf = (op_q != OP_REF);
    assign busy_buf     = buf_q;
    assign precharged   = pre_q;
    assign ld_en        = last_stage && (op_q == OP_RD2B);
    assign ld_buf       = buf_q;
    assign ld_data      = mem[row_q];

    // Sequence array commands and apply their effect on the final stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            op_q      <= OP_IDLE;
            row_q     <= '0;
            buf_q     <= '0;
            restore_q <= 1'b0;
            snap      <= '0;
            pre_q     <= 1'b1;
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else begin
            if (acc_pre) pre_q <= 1'b1;
            if (acc_arr) begin
                pre_q     <= 1'b0;
                cnt       <= CNT_START;
                op_q      <= op_in;
                row_q     <= row_in;
                buf_q     <= buf_in;
                restore_q <= restore_in;
                snap      <= buf_row_in;
            end else if (busy) begin
                cnt <= cnt - CNT_W'(1);
            end
            if (last_stage) begin
                if (op_q == OP_RD2B && !restore_q) mem[row_q] <= '0;
                else if (op_q == OP_WR2B)          mem[row_q] <= snap;
            end
        end
    end
endmodule

// File: rtl/rbank_buffers.sv
// Static row buffer file: NBUF registers, each one whole row wide. There is a
// whole-row load port from the array, a word write port from the bus, a word
// read port and a whole-row read port. Assumes a row load and a word write
// never target the same buffer in the same cycle.
module rbank_buffers #(
    parameter int NBUF   = 2,
    parameter int WORDS  = 4,
    parameter int WIDTH  = 64,
    parameter int BUF_W  = 1,
    parameter int WORD_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_en,
    input  logic [BUF_W-1:0]       ld_buf,
    input  logic [WORDS*WIDTH-1:0] ld_data,
    input  logic                   wr_en,
    input  logic [BUF_W-1:0]       wr_buf,
    input  logic [WORD_W-1:0]      wr_word,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic [BUF_W-1:0]       rd_buf,
    input  logic [WORD_W-1:0]      rd_word,
    output logic [WIDTH-1:0]       rd_data,
    input  logic [BUF_W-1:0]       row_sel,
    output logic [WORDS*WIDTH-1:0] row_data
);
    localparam int ROW_BITS = WORDS * WIDTH;

    logic [ROW_BITS-1:0] bufs [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic [ROW_BITS-1:0] row_q;

        // Hold one open row; take a full row load or a single word update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else begin
                if (ld_en && ld_buf == BUF_W'(b)) row_q <= ld_data;
                if (wr_en && wr_buf == BUF_W'(b)) row_q[wr_word*WIDTH +: WIDTH] <= wr_data;
            end
        end
        assign bufs[b] = row_q;
    end

    assign rd_data  = bufs[rd_buf][rd_word*WIDTH +: WIDTH];
    assign row_data = bufs[row_sel];
endmodule

// File: rtl/rbank_wordport.sv
// Two-stage word path between the buffers and the section bus.
// Read: select the word, then drive the bus (valid two cycles after the
// command). Write: capture from the bus, then latch into the buffer.
// The bus output is forced to zero when no read result is present.
module rbank_wordport #(
    parameter int WIDTH  = 64,
    parameter int BUF_W  = 1,
    parameter int WORD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [BUF_W-1:0]  cmd_buf,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  sel_data,
    output logic              wr_en,
    output logic [BUF_W-1:0]  wr_buf,
    output logic [WORD_W-1:0] wr_word,
    output logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rdata,
    output logic              rvalid
);
    logic             rd_v1;
    logic [WIDTH-1:0] rd_q;

    // Pipeline read selection and bus drive, and stage bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v1   <= 1'b0;
            rd_q    <= '0;
            rvalid  <= 1'b0;
            rdata   <= '0;
            wr_en   <= 1'b0;
            wr_buf  <= '0;
            wr_word <= '0;
            wr_data <= '0;
        end else begin
            rd_v1   <= acc_rd;
            rd_q    <= sel_data;
            rvalid  <= rd_v1;
            rdata   <= rd_v1 ? rd_q : '0;
            wr_en   <= acc_wr;
            wr_buf  <= cmd_buf;
            wr_word <= cmd_word;
            wr_data <= wdata;
        end
    end
endmodule

// File: rtl/rbank_engine.sv
// Top of one row-buffered memory bank. Connects the decoder, the array
// sequencer, the row buffer file and the word port, and registers the
// reject strobe. Assumes ROWS, WORDS and NBUF are each at least 1 and
// that indices on the command bus are within range.
module rbank_engine #(
    parameter int ROWS    = 8,
    parameter int WORDS   = 4,
    parameter int WIDTH   = 64,
    parameter int NBUF    = 2,
    parameter int BANK_W  = 2,
    parameter int BANK_ID = 1,
    localparam int ROW_W  = (ROWS  > 1) ? $clog2(ROWS)  : 1,
    localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BUF_W  = (NBUF  > 1) ? $clog2(NBUF)  : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [BUF_W-1:0]  cmd_buf,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_restore,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    output logic              rvalid,
    output logic              ready,
    output logic              precharged,
    output logic              err
);
    localparam int ROW_BITS = WORDS * WIDTH;

    logic                acc_pre, acc_arr, acc_rd, acc_wr, reject;
    logic                busy, busy_has_buf;
    logic [BUF_W-1:0]    busy_buf;
    logic                ld_en;
    logic [BUF_W-1:0]    ld_buf;
    logic [ROW_BITS-1:0] ld_data;
    logic [ROW_BITS-1:0] buf_row;
    logic [WIDTH-1:0]    sel_data;
    logic                wr_en;
    logic [BUF_W-1:0]    wr_buf;
    logic [WORD_W-1:0]   wr_word;
    logic [WIDTH-1:0]    wr_data;

    rbank_decode #(.BANK_W(BANK_W), .BANK_ID(BANK_ID), .BUF_W(BUF_W)) u_decode (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_buf(cmd_buf),
        .busy(busy), .precharged(precharged), .busy_has_buf(busy_has_buf),
        .busy_buf(busy_buf), .acc_pre(acc_pre), .acc_arr(acc_arr),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .reject(reject)
    );

    rbank_array #(.ROWS(ROWS), .ROW_W(ROW_W), .BUF_W(BUF_W), .ROW_BITS(ROW_BITS)) u_array (
        .clk(clk), .rst_n(rst_n), .acc_pre(acc_pre), .acc_arr(acc_arr),
        .op_in(cmd_op), .row_in(cmd_row), .buf_in(cmd_buf), .restore_in(cmd_restore),
        .buf_row_in(buf_row), .busy(busy), .busy_has_buf(busy_has_buf),
        .busy_buf(busy_buf), .precharged(precharged), .ld_en(ld_en),
        .ld_buf(ld_buf), .ld_data(ld_data)
    );

    rbank_buffers #(.NBUF(NBUF), .WORDS(WORDS), .WIDTH(WIDTH), .BUF_W(BUF_W),
                    .WORD_W(WORD_W)) u_buffers (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_buf(ld_buf), .ld_data(ld_data),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_word(wr_word), .wr_data(wr_data),
        .rd_buf(cmd_buf), .rd_word(cmd_word), .rd_data(sel_data),
        .row_sel(cmd_buf), .row_data(buf_row)
    );

    rbank_wordport #(.WIDTH(WIDTH), .BUF_W(BUF_W), .WORD_W(WORD_W)) u_wordport (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .cmd_buf(cmd_buf), .cmd_word(cmd_word), .wdata(wdata), .sel_data(sel_data),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_word(wr_word), .wr_data(wr_data),
        .rdata(rdata), .rvalid(rvalid)
    );

    assign ready = !busy;

    // Flag a rejected command for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= reject;
    end
endmodule

// File: rtl/rbank_engine_chk.sv
// Protocol checker for rbank_engine, attached through bind. Observes only
// the command inputs and the status and bus outputs.
module rbank_engine_chk #(
    parameter int BANK_W  = 2,
    parameter int BANK_ID = 1,
    parameter int WIDTH   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              ready,
    input logic              precharged,
    input logic              err,
    input logic              rvalid,
    input logic [WIDTH-1:0]  rdata
);
    logic hit, arr_cmd;
    assign hit     = cmd_valid && (cmd_bank == BANK_W'(BANK_ID));
    assign arr_cmd = hit && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd6);

    p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !hit) |=> !err);

    p_need_precharge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd && !precharged) |=> err);

    p_array_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd && ready && precharged) |=> (!ready && !precharged && !err));

    p_precharge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmd_op == 3'd1 && ready) |=> precharged);

    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmd_op == 3'd4 && ready) |=> ##1 rvalid);

    p_bus_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    p_busy_refuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd && !ready) |=> err);

    p_busy_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |=> (!ready ##1 ready));

    p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(hit));
endmodule

bind rbank_engine rbank_engine_chk #(.BANK_W(BANK_W), .BANK_ID(BANK_ID), .WIDTH(WIDTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .ready(ready), .precharged(precharged), .err(err),
    .rvalid(rvalid), .rdata(rdata)
);

// File: tb/test_rbank_engine.sv
// Bench for rbank_engine: a behavioural reference model updated on each
// rising edge, compared with the outputs on every falling edge, plus
// directed scenarios with checks against values known in advance.
module test_rbank_engine;
    localparam int ROWS = 8, WORDS = 4, WIDTH = 64, NBUF = 2, BANK_W = 2, BID = 1;
    localparam int ROW_W = 3, WORD_W = 2, BUF_W = 1;
    localparam logic [63:0] A = 64'hA0A0_0000_0000_0000;
    localparam logic [63:0] B = 64'hB0B0_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [ROW_W-1:0] cmd_row = '0;
    logic [BUF_W-1:0] cmd_buf = '0;
    logic [WORD_W-1:0] cmd_word = '0;
    logic cmd_restore = 1'b0;
    logic [WIDTH-1:0] wdata = '0;
    logic [WIDTH-1:0] rdata;
    logic rvalid, ready, precharged, err;

    always #2 clk = ~clk;

    rbank_engine #(.ROWS(ROWS), .WORDS(WORDS), .WIDTH(WIDTH), .NBUF(NBUF),
                   .BANK_W(BANK_W), .BANK_ID(BID)) i_rbank_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_buf(cmd_buf),
        .cmd_word(cmd_word), .cmd_restore(cmd_restore), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .ready(ready),
        .precharged(precharged), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model state.
    logic [63:0] mm [ROWS][WORDS];
    logic [63:0] bm [NBUF][WORDS];
    logic [63:0] a_snap [WORDS];
    int busy_left, a_op, a_row, a_buf;
    bit a_rst, m_pre, pw_v, s1_v, x_rv, x_err;
    int pw_b, pw_w;
    logic [63:0] pw_d, s1_d, x_rd;

    // Advance the model by one clock, following the requirements.
    always @(posedge clk) begin : model
        bit hit, arr, conflict, pre_ok, arr_ok, rd_ok, wr_ok, rej;
        logic [63:0] nsnap [WORDS];
        logic [63:0] nrd;
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) for (int w = 0; w < WORDS; w++) mm[r][w] = '0;
            for (int b = 0; b < NBUF; b++) for (int w = 0; w < WORDS; w++) bm[b][w] = '0;
            busy_left = 0; a_op = 0; a_row = 0; a_buf = 0; a_rst = 0; m_pre = 1;
            pw_v = 0; s1_v = 0; s1_d = '0; x_rv = 0; x_rd = '0; x_err = 0;
        end else begin
            hit      = cmd_valid && cmd_bank == BANK_W'(BID) && cmd_op != 3'd0;
            arr      = cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd6;
            conflict = busy_left > 0 && a_op != 6 && int'(cmd_buf) == a_buf;
            pre_ok   = hit && cmd_op == 3'd1 && busy_left == 0;
            arr_ok   = hit && arr && busy_left == 0 && m_pre;
            rd_ok    = hit && cmd_op == 3'd4 && !conflict;
            wr_ok    = hit && cmd_op == 3'd5 && !conflict;
            rej      = hit && !(pre_ok || arr_ok || rd_ok || wr_ok);
            nrd      = bm[cmd_buf][cmd_word];
            nsnap    = bm[cmd_buf];
            if (busy_left == 1) begin
                if (a_op == 2) begin
                    bm[a_buf] = mm[a_row];
                    if (!a_rst) for (int w = 0; w < WORDS; w++) mm[a_row][w] = '0;
                end else if (a_op == 3) begin
                    mm[a_row] = a_snap;
                end
            end
            if (pw_v) bm[pw_b][pw_w] = pw_d;
            if (busy_left > 0) busy_left--;
            if (arr_ok) begin
                busy_left = 2; a_op = int'(cmd_op); a_row = int'(cmd_row);
                a_buf = int'(cmd_buf); a_rst = cmd_restore; a_snap = nsnap; m_pre = 0;
            end
            if (pre_ok) m_pre = 1;
            pw_v = wr_ok; pw_b = int'(cmd_buf); pw_w = int'(cmd_word); pw_d = wdata;
            x_rv = s1_v; x_rd = s1_v ? s1_d : '0;
            s1_v = rd_ok; s1_d = nrd;
            x_err = rej;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R10 ready", 64'(ready), 64'(busy_left == 0));
            chk("R2 precharged", 64'(precharged), 64'(m_pre));
            chk("R11 err", 64'(err), 64'(x_err));
            chk("R7 rvalid", 64'(rvalid), 64'(x_rv));
            chk("R8 rdata", rdata, x_rd);
        end
    end

    task automatic cmd(input logic [2:0] op, input int bank, input int row,
                       input int b, input int w, input bit rs, input logic [63:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = BANK_W'(bank); cmd_row = ROW_W'(row);
        cmd_buf = BUF_W'(b); cmd_word = WORD_W'(w); cmd_restore = rs; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
        end
    endtask

    task automatic rd_chk(input int b, input int w, input logic [63:0] exp, input string tag);
        cmd(3'd4, BID, 0, b, w, 0, '0);
        idle(2);
        chk({tag, " read valid"}, 64'(rvalid), 64'd1);
        chk({tag, " read data"}, rdata, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk("R13 ready", 64'(ready), 64'd1);
        chk("R13 precharged", 64'(precharged), 64'd1);
        chk("R13 rvalid", 64'(rvalid), 64'd0);
        chk("R13 err", 64'(err), 64'd0);
        rd_chk(0, 0, 64'd0, "R13");
        @(negedge clk);
        chk("R7 single pulse", 64'(rvalid), 64'd0);
        chk("R8 idle bus", rdata, 64'd0);

        // R9: fill buffer 0 with words
        for (int i = 0; i < WORDS; i++) cmd(3'd5, BID, 0, 0, i, 0, A + 64'(i));
        idle(2);
        rd_chk(0, 2, A + 64'd2, "R9");

        // R5: write buffer 0 back to row 3
        cmd(3'd3, BID, 3, 0, 0, 0, '0);
        idle(3);
        chk("R2 active after array cmd", 64'(precharged), 64'd0);
        cmd(3'd6, BID, 1, 0, 0, 0, '0);
        idle(1);
        chk("R2 refused without precharge", 64'(err), 64'd1);
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        idle(1);
        chk("R2 precharge", 64'(precharged), 64'd1);

        // R3: fetch row 3 into buffer 1 with restore
        cmd(3'd2, BID, 3, 1, 0, 1, '0);
        idle(3);
        rd_chk(1, 1, A + 64'd1, "R3");

        // R10: word ops during a fetch into buffer 0
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd2, BID, 5, 0, 0, 1, '0);
        cmd(3'd4, BID, 0, 1, 0, 0, '0);
        chk("R10 ready low", 64'(ready), 64'd0);
        cmd(3'd5, BID, 0, 0, 0, 0, 64'hFFFF);
        idle(1);
        chk("R11 refused same buffer", 64'(err), 64'd1);
        chk("R10 other buffer read valid", 64'(rvalid), 64'd1);
        chk("R10 other buffer read data", rdata, A);
        idle(2);
        rd_chk(0, 0, 64'd0, "R10");

        // R4 / R12: lost row after fetch without restore
        for (int i = 0; i < WORDS; i++) cmd(3'd5, BID, 0, 0, i, 0, B + 64'(i));
        idle(2);
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd3, BID, 6, 0, 0, 0, '0);
        idle(3);
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd2, BID, 6, 1, 0, 0, '0);
        idle(3);
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd2, BID, 6, 0, 0, 1, '0);
        idle(3);
        rd_chk(0, 1, 64'd0, "R4 lost row");
        rd_chk(1, 1, B + 64'd1, "R12");
        rd_chk(1, 3, B + 64'd3, "R4");

        // R4: restored row survives a second fetch
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd2, BID, 3, 0, 0, 1, '0);
        idle(3);
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd2, BID, 3, 0, 0, 1, '0);
        idle(3);
        rd_chk(0, 1, A + 64'd1, "R4 restored");

        // R6: refresh leaves buffers intact
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd6, BID, 3, 0, 0, 0, '0);
        idle(1);
        chk("R6 ready low", 64'(ready), 64'd0);
        idle(2);
        rd_chk(1, 1, B + 64'd1, "R6");
        rd_chk(0, 2, A + 64'd2, "R6");
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd2, BID, 3, 0, 0, 1, '0);
        idle(3);
        rd_chk(0, 3, A + 64'd3, "R6 row intact");

        // R5: write-back of buffer 1 to row 2
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd3, BID, 2, 1, 0, 0, '0);
        idle(3);
        cmd(3'd1, BID, 0, 0, 0, 0, '0);
        cmd(3'd2, BID, 2, 0, 0, 1, '0);
        idle(3);
        rd_chk(0, 3, B + 64'd3, "R5");

        // R1: foreign bank commands
        cmd(3'd5, 2, 0, 0, 3, 0, 64'h1234);
        cmd(3'd4, 0, 0, 0, 3, 0, '0);
        cmd(3'd1, 3, 0, 0, 0, 0, '0);
        idle(1);
        chk("R1 no err", 64'(err), 64'd0);
        chk("R1 no precharge", 64'(precharged), 64'd0);
        idle(1);
        chk("R1 no read", 64'(rvalid), 64'd0);
        rd_chk(0, 3, B + 64'd3, "R1");
        idle(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule